// File: doc/BRIEF.md
# MDIO Management Write Frame Master

This block sends one clause-22 management write to a PHY over a two-wire management interface. A single-cycle command carries a 5-bit PHY address, a 5-bit register number and a 16-bit value. The block then generates the management clock from the system clock through a half-period divider. It drives the data line, with a separate output-enable, through one fixed frame of 65 management clocks.

The frame has four parts. The preamble is all ones. Then come the start and write codes, then the two address fields, and then two tristated turnaround clocks. Last come the 16 data bits and one closing tristated clock. Each bit is placed on the line while the clock is low and held through the high half. The incoming data line is sampled at the end of every high half, and the last sixteen samples are kept so that a read variant could use them.

`busy` is high for the whole frame, and `done` pulses once when the frame ends. After the frame the block parks with the clock low, the data low and the output disabled.

Top module: `mdio_wr_master`

## Requirements
- R1: While not busy (including reset), `mdc`, `mdioOut` and `mdioOe` are all 0.
- R2: Frame clocks 0 to 31 (first clock = 0) drive `mdioOut` = 1 with `mdioOe` = 1.
- R3: Clocks 32 to 35 drive the bits 0,1,0,1 (start code then write opcode), with the output enabled.
- R4: Clocks 36 to 40 carry the PHY address and clocks 41 to 45 carry the register number, both most significant bit first, with the output enabled.
- R5: Clocks 46 and 47 have `mdioOe` = 0 and `mdioOut` = 0.
- R6: Clocks 48 to 63 carry the write data most significant bit first, with the output enabled. Clock 64 is tristated with `mdioOut` = 0, and no further clock follows.
- R7: Each management clock is low for HALF_PERIOD system clocks and then high for HALF_PERIOD system clocks. The first low half begins in the cycle after the command is accepted. `mdioOut` and `mdioOe` change only at the start of a low half.
- R8: `mdioIn` is sampled on the system clock edge that ends each high half. `rdData` shifts left by one with the new sample entering bit 0.
- R9: A command (`cmdValid` = 1 while `busy` = 0) sets `busy` on the next edge. `busy` stays high for 130×HALF_PERIOD cycles. A command presented while `busy` is 1 is ignored.
- R10: `done` is 1 for exactly one cycle, in the same cycle that `busy` falls after clock 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdPhyAddr | input | 5 | PHY address for the frame |
| cmdRegAddr | input | 5 | Register number for the frame |
| cmdData | input | 16 | Write data |
| mdioIn | input | 1 | Data line as seen from the pad |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line output value |
| mdioOe | output | 1 | Data line output enable |
| rdData | output | 16 | Last sixteen sampled `mdioIn` bits |

## Verification
Frames are sent with alternating address and data bits, with every field all ones, and with every field all zero. These patterns tell a correct field order and bit order apart from swapped or reversed fields, and they expose constant outputs in the turnaround and closing clocks. A second command is held during a frame to show that it is dropped. Another command is held across the end of a frame to show that it is accepted in the cycle after `done`. `mdioIn` follows a pseudo-random sequence, so a sample taken on the wrong edge gives a different `rdData`.

// File: rtl/mdio_wr_pkg.sv
package mdio_wr_pkg;
  localparam int FRAME_CLKS = 65;
  localparam int IDX_W      = 7;
  localparam int LAST_IDX   = FRAME_CLKS - 1;
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;

  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic finish;
    logic nextOe;
  } mdioStrobe_t;

  function automatic logic oeFor(input logic [IDX_W-1:0] idx);
    return (idx < IDX_W'(LAST_IDX)) && (idx != IDX_W'(TA_FIRST)) && (idx != IDX_W'(TA_SECOND));
  endfunction
endpackage

// File: rtl/mdio_wr_ctrl.sv
module mdio_wr_ctrl
  import mdio_wr_pkg::*;
#(
  parameter int HALF_PERIOD = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  output logic        busy,
  output logic        done,
  output mdioStrobe_t strobe
);
  localparam int DIV_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_PERIOD - 1);

  logic [DIV_W-1:0] divCnt;
  logic             phaseHigh;
  logic [IDX_W-1:0] bitIdx;
  logic             halfEnd;
  logic             lastBit;

  assign halfEnd = busy && (divCnt == DIV_END);
  assign lastBit = (bitIdx == IDX_W'(LAST_IDX));

  always_comb begin
    strobe.load   = cmdValid && !busy;
    strobe.rise   = halfEnd && !phaseHigh;
    strobe.fall   = halfEnd && phaseHigh && !lastBit;
    strobe.finish = halfEnd && phaseHigh && lastBit;
    strobe.nextOe = oeFor(bitIdx + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      divCnt    <= '0;
      phaseHigh <= 1'b0;
      bitIdx    <= '0;
    end else begin
      done <= strobe.finish;
      if (strobe.load) begin
        busy      <= 1'b1;
        divCnt    <= '0;
        phaseHigh <= 1'b0;
        bitIdx    <= '0;
      end else if (busy) begin
        if (halfEnd) begin
          divCnt    <= '0;
          phaseHigh <= !phaseHigh;
          if (phaseHigh) begin
            if (lastBit) busy <= 1'b0;
            else         bitIdx <= bitIdx + 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_wr_datapath.sv
module mdio_wr_datapath
  import mdio_wr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  mdioStrobe_t strobe,
  input  logic [4:0]  cmdPhyAddr,
  input  logic [4:0]  cmdRegAddr,
  input  logic [15:0] cmdData,
  input  logic        mdioIn,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic [15:0] rdData
);
  logic [FRAME_CLKS-1:0] shifter;
  logic [FRAME_CLKS-1:0] frameImage;

  assign frameImage = {32'hFFFF_FFFF, 2'b01, 2'b01, cmdPhyAddr, cmdRegAddr, 2'b00, cmdData, 1'b0};
  assign mdioOut    = shifter[FRAME_CLKS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shifter <= '0;
      mdc     <= 1'b0;
      mdioOe  <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strobe.load) begin
        shifter <= frameImage;
        mdioOe  <= 1'b1;
        mdc     <= 1'b0;
      end else if (strobe.rise) begin
        mdc <= 1'b1;
      end else if (strobe.fall) begin
        mdc     <= 1'b0;
        shifter <= shifter << 1;
        mdioOe  <= strobe.nextOe;
      end else if (strobe.finish) begin
        mdc     <= 1'b0;
        shifter <= '0;
        mdioOe  <= 1'b0;
      end
      if (strobe.fall || strobe.finish) rdData <= {rdData[14:0], mdioIn};
    end
  end
endmodule

// File: rtl/mdio_wr_master.sv
module mdio_wr_master
  import mdio_wr_pkg::*;
#(
  parameter int HALF_PERIOD = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  input  logic [4:0]  cmdPhyAddr,
  input  logic [4:0]  cmdRegAddr,
  input  logic [15:0] cmdData,
  input  logic        mdioIn,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic [15:0] rdData
);
  mdioStrobe_t strobe;

  mdio_wr_ctrl #(.HALF_PERIOD(HALF_PERIOD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid),
    .busy(busy), .done(done), .strobe(strobe)
  );

  mdio_wr_datapath u_datapath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .cmdPhyAddr(cmdPhyAddr), .cmdRegAddr(cmdRegAddr), .cmdData(cmdData),
    .mdioIn(mdioIn), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdData)
  );
endmodule

// File: rtl/mdio_wr_checker.sv
module mdio_wr_checker #(
  parameter int HALF_PERIOD = 4
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe
);
  logic        mdcQ;
  logic [31:0] runLen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdcQ   <= 1'b0;
      runLen <= 32'd0;
    end else begin
      mdcQ   <= mdc;
      runLen <= (mdc != mdcQ) ? 32'd1 : runLen + 32'd1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdioOut && !mdioOe));

  p_hold_while_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdioOut) && $stable(mdioOe)));

  p_high_half_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdc && mdcQ) |-> (runLen == 32'(HALF_PERIOD)));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind mdio_wr_master mdio_wr_checker #(.HALF_PERIOD(HALF_PERIOD)) u_mdio_wr_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/mdio_wr_master_bench.sv
module mdio_wr_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HP         = 3;
  localparam int FRAME_LEN  = 130 * HP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [4:0] cmdPhyAddr = '0;
  logic [4:0] cmdRegAddr = '0;
  logic [15:0] cmdData = '0;
  logic mdioIn = 1'b0;
  logic busy, done, mdc, mdioOut, mdioOe;
  logic [15:0] rdData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  bit   mBusy = 0;
  bit   mDone = 0;
  int   t = 0;
  bit   mBits[$];
  logic [15:0] mCap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_wr_master #(.HALF_PERIOD(HP)) u_mdio_wr_master (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdPhyAddr(cmdPhyAddr),
    .cmdRegAddr(cmdRegAddr), .cmdData(cmdData), .mdioIn(mdioIn),
    .busy(busy), .done(done), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdData)
  );

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cycles, act, exp);
    end
  endtask

  function automatic string tagFor(input int k);
    if (k < 32) return "R2";
    if (k < 36) return "R3";
    if (k < 46) return "R4";
    if (k < 48) return "R5";
    return "R6";
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mBusy = 0; mDone = 0; t = 0; mCap = '0;
    end else begin
      mDone = 0;
      if (mBusy) begin
        t++;
        if (t % (2*HP) == 0) mCap = {mCap[14:0], mdioIn};
        if (t == FRAME_LEN) begin mBusy = 0; mDone = 1; end
      end else if (cmdValid) begin
        mBusy = 1; t = 0;
        mBits.delete();
        for (int i = 0; i < 32; i++) mBits.push_back(1'b1);
        mBits.push_back(1'b0); mBits.push_back(1'b1);
        mBits.push_back(1'b0); mBits.push_back(1'b1);
        for (int i = 4; i >= 0; i--) mBits.push_back(cmdPhyAddr[i]);
        for (int i = 4; i >= 0; i--) mBits.push_back(cmdRegAddr[i]);
        mBits.push_back(1'b0); mBits.push_back(1'b0);
        for (int i = 15; i >= 0; i--) mBits.push_back(cmdData[i]);
        mBits.push_back(1'b0);
      end
    end
  end

  // compare away from the active edge; also drive mdioIn here
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      int k;
      logic eMdc, eOut, eOe;
      if (mBusy) begin
        k    = t / (2*HP);
        eMdc = (t % (2*HP)) >= HP;
        eOut = mBits[k];
        eOe  = (k < 64) && (k != 46) && (k != 47);
        check("R7", "mdc", 16'(mdc), 16'(eMdc));
        check(tagFor(k), "mdioOut", 16'(mdioOut), 16'(eOut));
        check(tagFor(k), "mdioOe", 16'(mdioOe), 16'(eOe));
      end else begin
        check("R1", "idle lines", {13'd0, mdc, mdioOut, mdioOe}, 16'd0);
      end
      check("R9", "busy", 16'(busy), 16'(mBusy));
      check("R10", "done", 16'(done), 16'(mDone));
      check("R8", "rdData", rdData, mCap);
    end
    lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mdioIn = lfsr[0];
  end

  task automatic sendCmd(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdPhyAddr = pa; cmdRegAddr = ra; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset mdc/out/oe", {13'd0, mdc, mdioOut, mdioOe}, 16'd0);
    check("R9", "reset busy", 16'(busy), 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // alternating field pattern, plus an ignored command mid-frame (R9)
    sendCmd(5'h15, 5'h0A, 16'hA5C3);
    repeat (50) @(negedge clk);
    sendCmd(5'h0E, 5'h11, 16'h1234);
    waitIdle();

    // all ones (R4, R6)
    sendCmd(5'h1F, 5'h1F, 16'hFFFF);
    waitIdle();

    // all zero (R4, R5, R6)
    sendCmd(5'h00, 5'h00, 16'h0000);
    waitIdle();

    // command held across frame end: reaccepted the cycle after done (R9, R10)
    @(negedge clk);
    cmdValid = 1'b1; cmdPhyAddr = 5'h01; cmdRegAddr = 5'h10; cmdData = 16'h8001;
    @(negedge clk);
    while (!done) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    waitIdle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule